// File: doc/BRIEF.md
# Serial Port FIFO Threshold and Handshake Controller

This block holds the byte queues of a serial port: one queue of bytes waiting to be sent and one queue of bytes already received. It raises two sticky status flags when the queue levels cross thresholds set by a small configuration word. The receive flag means "enough data has arrived to be worth reading". The transmit flag means "the send queue has drained far enough to be refilled". The shifter, baud timing, framing and error checks sit outside and connect through the stream ports.

Both queues use valid/ready streams on the way in and on the way out. A producer may hold `*_in_valid` while `*_in_ready` is low. Each such cycle counts as an attempt to write into a full queue: the byte is dropped, the level is left as it was, and an overflow strobe pulses. A consumer that raises `*_out_ready` while the queue is empty gets an underflow strobe and no change of level. The send queue's output valid is also held low while the clear-to-send line forbids a new byte. Back-pressure then holds the head byte in place until the line allows it.

The configuration word is 5 bits wide: bits [4:3] are the receive trigger code, bits [2:1] the transmit trigger code, and bit [0] is the handshake enable. A mode input selects asynchronous (0) or synchronous (1) operation. Each status flag has a clear strobe for software.

Top module: `sfifo_trig_ctrl`

## Requirements
- R1: While reset is asserted, both queues are empty, both flags are 0 and `rts_n` is 0. The configuration word resets to all zeros, which gives a receive threshold of 1 byte, a transmit threshold of 8 bytes, and handshake disabled.
- R2: In asynchronous mode (`mode_sync`=0), receive trigger codes 00, 01, 10 and 11 select thresholds of 1, 4, 8 and 14 bytes.
- R3: In synchronous mode (`mode_sync`=1), the same codes select thresholds of 1, 2, 8 and 14 bytes.
- R4: `rdf` becomes 1 on the clock edge after the receive level is at or above the receive threshold.
- R5: Transmit trigger codes 00, 01, 10 and 11 select remaining-byte thresholds of 8, 4, 2 and 0. `tdfe` becomes 1 on the clock edge after the send level is at or below that threshold.
- R6: Each flag stays at 1 until its clear strobe is sampled while its condition is false; the flag is then 0 after that edge. A clear strobe sampled while the condition holds has no effect.
- R7: With handshake disabled (bit [0] = 0), `cts_n` is ignored (treated as low) and `rts_n` is driven to 0.
- R8: In synchronous mode the handshake enable bit is ignored and the disabled behaviour of R7 applies.
- R9: With handshake enabled in asynchronous mode, `rts_n` is 0 while the free receive space is at or above the receive threshold, and 1 otherwise.
- R10: With handshake enabled in asynchronous mode, `tx_out_valid` is 0 while `cts_n` is 1, and the head byte is kept.
- R11: A write attempt into a full queue is dropped, leaves the level unchanged, and makes the overflow strobe 1 for exactly the cycle after the attempt.
- R12: A read attempt from an empty queue leaves the level unchanged and makes the underflow strobe 1 for exactly the cycle after the attempt.
- R13: Each queue delivers bytes in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration word: [4:3] receive code, [2:1] transmit code, [0] handshake enable |
| mode_sync | input | 1 | 0 asynchronous, 1 synchronous |
| tx_in_valid | input | 1 | Send queue write valid |
| tx_in_ready | output | 1 | Send queue has room |
| tx_in_data | input | DW | Byte to send |
| tx_out_valid | output | 1 | Head byte available to the shifter |
| tx_out_ready | input | 1 | Shifter takes the head byte |
| tx_out_data | output | DW | Head byte of the send queue |
| rx_in_valid | input | 1 | Received byte valid |
| rx_in_ready | output | 1 | Receive queue has room |
| rx_in_data | input | DW | Received byte |
| rx_out_valid | output | 1 | Receive queue not empty |
| rx_out_ready | input | 1 | Reader takes the head byte |
| rx_out_data | output | DW | Head byte of the receive queue |
| rdf | output | 1 | Receive threshold flag |
| rdf_clr | input | 1 | Clear strobe for `rdf` |
| tdfe | output | 1 | Transmit threshold flag |
| tdfe_clr | input | 1 | Clear strobe for `tdfe` |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| tx_ovf | output | 1 | Send queue overflow strobe |
| tx_udf | output | 1 | Send queue underflow strobe |
| rx_ovf | output | 1 | Receive queue overflow strobe |
| rx_udf | output | 1 | Receive queue underflow strobe |

## Verification
The bench builds the block with its defaults, DEPTH=16 and DW=8. At this depth the derived thresholds are exactly 1/4/8/14 and 1/2/8/14 for receive, and 8/4/2/0 for transmit. Each threshold is approached from one byte short, so the flag is seen staying clear and then setting. The small depth also makes a completely full queue and a completely empty queue cheap to reach, so the dropped write, the empty read, and the 13-byte free-space edge of the request-to-send line are exercised directly.

// File: rtl/sfifo_trig_pkg.sv
package sfifo_trig_pkg;

  typedef struct packed {
    logic [1:0] rx_code;
    logic [1:0] tx_code;
    logic       mce;
  } sfifo_cfg_t;

  // Receive threshold in bytes; code 01 differs between the two modes.
  function automatic int unsigned rx_level(input logic [1:0] code,
                                           input logic sync,
                                           input int unsigned depth);
    unique case (code)
      2'd0:    return 1;
      2'd1:    return sync ? depth / 8 : depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  // Remaining-byte threshold for the send queue.
  function automatic int unsigned tx_level(input logic [1:0] code,
                                           input int unsigned depth);
    unique case (code)
      2'd0:    return depth / 2;
      2'd1:    return depth / 4;
      2'd2:    return depth / 8;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sfifo_byte_fifo.sv
module sfifo_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          out_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] level,
  output logic          ovf,
  output logic          udf
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          empty, full, push, pop;

  assign empty     = (level == '0);
  assign full      = (level == CW'(DEPTH));
  assign in_ready  = !full;
  assign out_valid = !empty && out_en;
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && !full;
  assign pop       = out_valid && out_ready;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
      ovf <= in_valid && full;
      udf <= out_ready && empty;
    end
  end

endmodule

// File: rtl/sfifo_thresh_dec.sv
module sfifo_thresh_dec
  import sfifo_trig_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  sfifo_cfg_t    cfg,
  input  logic          mode_sync,
  output logic [CW-1:0] rx_thr,
  output logic [CW-1:0] tx_thr
);

  always_comb begin
    rx_thr = CW'(rx_level(cfg.rx_code, mode_sync, DEPTH));
    tx_thr = CW'(tx_level(cfg.tx_code, DEPTH));
  end

endmodule

// File: rtl/sfifo_level_flag.sv
module sfifo_level_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clr,
  output logic flag
);

  // Condition wins over a clear strobe in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (cond) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

endmodule

// File: rtl/sfifo_trig_ctrl.sv
module sfifo_trig_ctrl
  import sfifo_trig_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_wdata,
  input  logic          mode_sync,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  output logic          rdf,
  input  logic          rdf_clr,
  output logic          tdfe,
  input  logic          tdfe_clr,
  input  logic          cts_n,
  output logic          rts_n,
  output logic          tx_ovf,
  output logic          tx_udf,
  output logic          rx_ovf,
  output logic          rx_udf
);

  sfifo_cfg_t    cfg_q;
  logic          cfg_mce_q;
  logic          hs_on, send_ok;
  logic [CW-1:0] rx_cnt, tx_cnt, rx_thr, tx_thr, rx_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= sfifo_cfg_t'(cfg_wdata);
  end

  assign cfg_mce_q = cfg_q.mce;
  // Handshake is honoured only in asynchronous mode.
  assign hs_on     = cfg_q.mce && !mode_sync;
  assign send_ok   = !hs_on || !cts_n;
  assign rx_free   = CW'(DEPTH) - rx_cnt;
  assign rts_n     = hs_on && (rx_free < rx_thr);

  sfifo_thresh_dec #(.DEPTH(DEPTH)) u_dec (
    .cfg       (cfg_q),
    .mode_sync (mode_sync),
    .rx_thr    (rx_thr),
    .tx_thr    (tx_thr)
  );

  sfifo_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   (tx_in_data),
    .out_en    (send_ok),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  (tx_out_data),
    .level     (tx_cnt),
    .ovf       (tx_ovf),
    .udf       (tx_udf)
  );

  sfifo_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_data   (rx_in_data),
    .out_en    (1'b1),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_out_data),
    .level     (rx_cnt),
    .ovf       (rx_ovf),
    .udf       (rx_udf)
  );

  sfifo_level_flag u_rdf (
    .clk   (clk),
    .rst_n (rst_n),
    .cond  (rx_cnt >= rx_thr),
    .clr   (rdf_clr),
    .flag  (rdf)
  );

  sfifo_level_flag u_tdfe (
    .clk   (clk),
    .rst_n (rst_n),
    .cond  (tx_cnt <= tx_thr),
    .clr   (tdfe_clr),
    .flag  (tdfe)
  );

endmodule

// File: rtl/sfifo_trig_ctrl_chk.sv
module sfifo_trig_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_sync,
  input logic          cts_n,
  input logic          rts_n,
  input logic          cfg_mce_q,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_thr,
  input logic [CW-1:0] tx_thr,
  input logic          rdf,
  input logic          rdf_clr,
  input logic          tdfe,
  input logic          tdfe_clr,
  input logic          tx_in_valid,
  input logic          tx_in_ready,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic          rx_in_valid,
  input logic          rx_in_ready,
  input logic          rx_out_valid,
  input logic          rx_out_ready,
  input logic          tx_ovf,
  input logic          tx_udf,
  input logic          rx_ovf,
  input logic          rx_udf
);

  p_rdf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt >= rx_thr) |=> rdf);

  p_tdfe_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= tx_thr) |=> tdfe);

  p_rdf_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdf_clr && rx_cnt < rx_thr) |=> !rdf);

  p_tdfe_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tdfe_clr && tx_cnt > tx_thr) |=> !tdfe);

  p_rts_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mce_q |-> !rts_n);

  p_sync_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sync |-> !rts_n);

  p_rts_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mce_q && !mode_sync && (int'(rx_cnt) + int'(rx_thr) > DEPTH)) |-> rts_n);

  p_cts_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid |-> (!cts_n || !cfg_mce_q || mode_sync));

  p_tx_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && !tx_in_ready) |=> tx_ovf);

  p_rx_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && !rx_in_ready && !(rx_out_valid && rx_out_ready)) |=> (rx_ovf && $stable(rx_cnt)));

  p_rx_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_ready && !rx_out_valid) |=> (rx_udf && $stable(rx_cnt)));

  p_tx_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_ready && tx_cnt == '0 && !tx_in_valid) |=> (tx_udf && tx_cnt == '0));

  p_level_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_cnt) <= DEPTH) && (int'(tx_cnt) <= DEPTH));

endmodule

bind sfifo_trig_ctrl sfifo_trig_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/sfifo_trig_ctrl_bench.sv
module sfifo_trig_ctrl_bench;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_we, mode_sync;
  logic [4:0] cfg_wdata;
  logic tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready;
  logic rx_in_valid, rx_in_ready, rx_out_valid, rx_out_ready;
  logic [DW-1:0] tx_in_data, tx_out_data, rx_in_data, rx_out_data;
  logic rdf, rdf_clr, tdfe, tdfe_clr, cts_n, rts_n;
  logic tx_ovf, tx_udf, rx_ovf, rx_udf;

  sfifo_trig_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_sfifo_trig_ctrl (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic set_cfg(logic [1:0] rc, logic [1:0] tc, logic m);
    cfg_we = 1'b1; cfg_wdata = {rc, tc, m};
    step();
    cfg_we = 1'b0;
  endtask

  task automatic push_rx(logic [7:0] b);
    rx_in_valid = 1'b1; rx_in_data = b;
    step();
    rx_in_valid = 1'b0;
  endtask

  task automatic push_tx(logic [7:0] b);
    tx_in_valid = 1'b1; tx_in_data = b;
    step();
    tx_in_valid = 1'b0;
  endtask

  task automatic pop_rx(logic [7:0] exp, string req);
    check(req, rx_out_valid, 1);
    check(req, rx_out_data, exp);
    rx_out_ready = 1'b1;
    step();
    rx_out_ready = 1'b0;
  endtask

  task automatic drain_rx();
    while (rx_out_valid) begin
      rx_out_ready = 1'b1; step(); rx_out_ready = 1'b0;
    end
  endtask

  task automatic drain_tx();
    while (tx_out_valid) begin
      tx_out_ready = 1'b1; step(); tx_out_ready = 1'b0;
    end
  endtask

  task automatic clr_rdf();
    rdf_clr = 1'b1; step(); rdf_clr = 1'b0;
  endtask

  task automatic clr_tdfe();
    tdfe_clr = 1'b1; step(); tdfe_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    check("R1 rdf in reset", rdf, 0);
    check("R1 tdfe in reset", tdfe, 0);
    check("R1 rts_n in reset", rts_n, 0);
    check("R1 tx empty", tx_out_valid, 0);
    check("R1 rx empty", rx_out_valid, 0);
    check("R1 tx room", tx_in_ready, 1);
    rst_n = 1'b1;
    step();
    check("R1 rdf idle", rdf, 0);
    push_rx(8'h11);
    step();
    check("R1 default rx threshold 1", rdf, 1);
    for (int i = 0; i < 9; i++) push_tx(8'(i));
    clr_tdfe();
    check("R1 default tx threshold 8, level 9", tdfe, 0);
    tx_out_ready = 1'b1; step(); tx_out_ready = 1'b0;
    step();
    check("R1 default tx threshold 8, level 8", tdfe, 1);
    drain_tx();
    drain_rx();
    clr_rdf();
  endtask

  task automatic t_rx_level(logic [1:0] code, logic sync, int thr, string req);
    mode_sync = sync;
    set_cfg(code, 2'b00, 1'b0);
    drain_rx();
    clr_rdf();
    for (int i = 0; i < thr - 1; i++) push_rx(8'(i));
    step();
    check({req, " below threshold"}, rdf, 0);
    push_rx(8'hA5);
    step();
    check({req, " R4 at threshold"}, rdf, 1);
    clr_rdf();
    check("R6 rdf clear ignored while level holds", rdf, 1);
    drain_rx();
    clr_rdf();
    check("R6 rdf clear once level low", rdf, 0);
    mode_sync = 1'b0;
  endtask

  task automatic t_tx_level(logic [1:0] code, int thr, string req);
    set_cfg(2'b00, code, 1'b0);
    for (int i = 0; i <= thr; i++) push_tx(8'(i));
    clr_tdfe();
    check({req, " above threshold"}, tdfe, 0);
    tx_out_ready = 1'b1; step(); tx_out_ready = 1'b0;
    step();
    check({req, " at threshold"}, tdfe, 1);
    clr_tdfe();
    check("R6 tdfe clear ignored while level holds", tdfe, 1);
    drain_tx();
  endtask

  task automatic t_overflow();
    set_cfg(2'b00, 2'b00, 1'b0);
    for (int i = 0; i < DEPTH; i++) push_rx(8'h40 + 8'(i));
    check("R11 rx full not ready", rx_in_ready, 0);
    push_rx(8'hEE);
    check("R11 overflow strobe", rx_ovf, 1);
    step();
    check("R11 overflow one cycle", rx_ovf, 0);
    for (int i = 0; i < DEPTH; i++) pop_rx(8'h40 + 8'(i), "R13 order after overflow");
    check("R11 dropped byte not stored", rx_out_valid, 0);
    clr_rdf();
  endtask

  task automatic t_underflow();
    tx_out_ready = 1'b1; step(); tx_out_ready = 1'b0;
    check("R12 underflow strobe", tx_udf, 1);
    step();
    check("R12 underflow one cycle", tx_udf, 0);
    push_tx(8'h5A);
    check("R12 level intact after underflow", tx_out_valid, 1);
    check("R13 tx head byte", tx_out_data, 8'h5A);
    rx_out_ready = 1'b1; step(); rx_out_ready = 1'b0;
    check("R12 rx underflow strobe", rx_udf, 1);
    drain_tx();
  endtask

  task automatic t_modem();
    mode_sync = 1'b0;
    cts_n = 1'b1;
    set_cfg(2'b11, 2'b00, 1'b1);
    check("R9 free 16 >= 14", rts_n, 0);
    for (int i = 0; i < 3; i++) push_rx(8'(i));
    check("R9 free 13 < 14", rts_n, 1);
    drain_rx();
    check("R9 free restored", rts_n, 0);
    push_tx(8'h77);
    check("R10 cts high blocks send", tx_out_valid, 0);
    tx_out_ready = 1'b1; step(); tx_out_ready = 1'b0;
    cts_n = 1'b0; #1;
    check("R10 cts low allows send", tx_out_valid, 1);
    check("R10 head byte kept", tx_out_data, 8'h77);
    cts_n = 1'b1;
    mode_sync = 1'b1;
    for (int i = 0; i < 3; i++) push_rx(8'(i));
    check("R8 sync forces rts low", rts_n, 0);
    check("R8 sync ignores cts", tx_out_valid, 1);
    mode_sync = 1'b0;
    set_cfg(2'b11, 2'b00, 1'b0);
    check("R7 disabled ignores cts", tx_out_valid, 1);
    check("R7 disabled rts low", rts_n, 0);
    drain_rx();
    drain_tx();
    cts_n = 1'b0;
    clr_rdf();
  endtask

  initial begin
    cfg_we = 0; cfg_wdata = '0; mode_sync = 0;
    tx_in_valid = 0; tx_in_data = '0; tx_out_ready = 0;
    rx_in_valid = 0; rx_in_data = '0; rx_out_ready = 0;
    rdf_clr = 0; tdfe_clr = 0; cts_n = 0; rst_n = 0;
    t_reset();
    t_rx_level(2'b00, 1'b0, 1,  "R2 async code 00");
    t_rx_level(2'b01, 1'b0, 4,  "R2 async code 01");
    t_rx_level(2'b10, 1'b0, 8,  "R2 async code 10");
    t_rx_level(2'b11, 1'b0, 14, "R2 async code 11");
    t_rx_level(2'b00, 1'b1, 1,  "R3 sync code 00");
    t_rx_level(2'b01, 1'b1, 2,  "R3 sync code 01");
    t_rx_level(2'b10, 1'b1, 8,  "R3 sync code 10");
    t_rx_level(2'b11, 1'b1, 14, "R3 sync code 11");
    t_tx_level(2'b00, 8, "R5 code 00");
    t_tx_level(2'b01, 4, "R5 code 01");
    t_tx_level(2'b10, 2, "R5 code 10");
    t_tx_level(2'b11, 0, "R5 code 11");
    t_overflow();
    t_underflow();
    t_modem();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule